// File: doc/BRIEF.md
# Triple 32-bit timer unit

This block holds three independent 32-bit counters behind a byte-wide register port. Each counter has its own enable, clock choice, direction and overflow enable. The clock choice is either every system clock or a single-cycle slow-tick enable that arrives from outside at roughly 32 kHz. Each counter also has a 32-bit compare value. A wrap past either end of the range is an overflow event. A compare hit is a match event. Both kinds of event are recorded as sticky status bits. A mask register picks which status bits may interrupt, and the resulting per-timer requests pass through a fixed two-stage delay before they reach the `irq` pins.

Software reaches every register one byte at a time. The port has no back-pressure: a write with `wr_en` high is taken at that clock edge. Read data is a combinational function of `addr`. All register state clears on an asynchronous active-low reset.

Top module: `tmr3_unit`

## Requirements
- R1: After reset, all counters, compare values, the control word, the mask and the status read as zero, and `irq` is 0.
- R2: Timer n's counter is at byte addresses 0x10*n+0 to 0x10*n+3 and its compare value is at 0x10*n+4 to 0x10*n+7. The least significant byte is at the lowest address. A write is visible on `rdata` from the next cycle.
- R3: The control word sits at 0x30 to 0x33 as one little-endian 32-bit value. Its bit 3n enables timer n, bit 3n+1 selects the slow tick (0 means every clock), bit 3n+2 enables the overflow event, and bit 9+n sets up-counting (0 means down). Bits 12 to 31 read as 0.
- R4: An enabled timer on the fast clock steps once per clock. An enabled timer on the slow tick steps only on cycles where `slow_tick` is 1. A disabled timer holds its value.
- R5: An up-counting timer wraps from 0xFFFFFFFF to 0. A down-counting timer wraps from 0 to 0xFFFFFFFF. A wrap sets status bit 3n+2 only when that timer's overflow enable is 1.
- R6: When a step produces a value equal to timer n's compare value, status bit 3n is set.
- R7: The status is at 0x34 (bits 0 to 7) and 0x35 (bit 8). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When an event and a clear hit the same bit in the same cycle, the bit stays set. Bits 3n+1 always read 0.
- R8: The mask is at 0x38 (bits 0 to 7) and 0x39 (bit 8). `irq[n]` is 1 exactly when status and mask share a set bit in group 3n to 3n+2, delayed by two clocks. It rises two edges after the edge that sets the status bit and falls two edges after the edge that clears it.
- R9: Events from all three timers in the same cycle are all recorded, and their `irq` bits rise together in the same cycle.
- R10: A write to any counter byte in a cycle overrides that timer's step in that cycle. The written byte takes the write data, and the other bytes keep their values.
- R11: Reads from unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_tick | input | 1 | Single-cycle slow count enable |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for `addr` |
| irq | output | 3 | Delayed per-timer interrupt requests |

## Verification
A counter that steps on the wrong condition shows up on `rdata` at the very next read of its bytes. This is visible within one cycle when the timer is on the slow tick, because the bench alone decides when it may move. Wrong wrap or compare detection shows up in the status byte in the same cycle as the faulty step. An error in the mask or the delay stage shows up as an `irq` edge one cycle early or late against the edge that set or cleared status. Clear-versus-event races and same-cycle events on all three timers are forced with the slow tick, so each such case is a single known cycle.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int unsigned TMR_N       = 3;
  localparam int unsigned BITS_PER_T  = 3;
  localparam int unsigned EV_W        = BITS_PER_T * TMR_N;
  localparam int unsigned CTRL_W      = EV_W + TMR_N;
  localparam int unsigned BANK_STRIDE = 16;
  localparam int unsigned MATCH_OFS   = 4;
  localparam int unsigned CTRL_BASE   = 8'h30;
  localparam int unsigned STAT_BASE   = 8'h34;
  localparam int unsigned MASK_BASE   = 8'h38;
endpackage

// File: rtl/tmr3_counter.sv
module tmr3_counter #(
  parameter int CW = 32,
  localparam int NB = CW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          up,
  input  logic [NB-1:0] cnt_we,
  input  logic [NB-1:0] mt_we,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] mt,
  output logic          ev_ovf,
  output logic          ev_match
);
  logic          load;
  logic          adv;
  logic [CW-1:0] nxt;

  always_comb begin
    load     = |cnt_we;
    adv      = step & ~load;
    nxt      = up ? cnt + 1'b1 : cnt - 1'b1;
    ev_ovf   = adv & (up ? (&cnt) : ~(|cnt));
    ev_match = adv & (nxt == mt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mt  <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (cnt_we[b])
          cnt[b*8 +: 8] <= wdata;
        else if (adv)
          cnt[b*8 +: 8] <= nxt[b*8 +: 8];
        if (mt_we[b])
          mt[b*8 +: 8] <= wdata;
      end
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !(|cnt_we)) |=> $stable(cnt));

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up && !(|cnt_we) && (&cnt)) |=> (cnt == '0));

  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we[0] |=> (cnt[7:0] == $past(wdata)));
endmodule

// File: rtl/tmr3_delay.sv
module tmr3_delay #(
  parameter int W     = 3,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/tmr3_unit.sv
module tmr3_unit
  import tmr3_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DLY   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic [7:0]       addr,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [TMR_N-1:0] irq
);
  localparam int NB = CNT_W / 8;

  logic [CTRL_W-1:0] ctrl_q;
  logic [EV_W-1:0]   mask_q, stat_q, ev, clr;
  logic [TMR_N-1:0]  pend, step, ev_ovf, ev_mt;
  logic [CNT_W-1:0]  cnt [TMR_N];
  logic [CNT_W-1:0]  mt  [TMR_N];

  for (genvar n = 0; n < TMR_N; n++) begin : g_tmr
    localparam int EN  = BITS_PER_T * n;
    localparam int SRC = BITS_PER_T * n + 1;
    localparam int OVE = BITS_PER_T * n + 2;
    localparam int DIR = EV_W + n;
    logic [NB-1:0] cwe, mwe;

    always_comb begin
      for (int b = 0; b < NB; b++) begin
        cwe[b] = wr_en && (addr == 8'(n * BANK_STRIDE + b));
        mwe[b] = wr_en && (addr == 8'(n * BANK_STRIDE + MATCH_OFS + b));
      end
    end

    assign step[n] = ctrl_q[EN] & (ctrl_q[SRC] ? slow_tick : 1'b1);

    tmr3_counter #(.CW(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step[n]),
      .up       (ctrl_q[DIR]),
      .cnt_we   (cwe),
      .mt_we    (mwe),
      .wdata    (wdata),
      .cnt      (cnt[n]),
      .mt       (mt[n]),
      .ev_ovf   (ev_ovf[n]),
      .ev_match (ev_mt[n])
    );

    assign ev[EN]  = ev_mt[n];
    assign ev[SRC] = 1'b0;
    assign ev[OVE] = ev_ovf[n] & ctrl_q[OVE];
    assign pend[n] = |(stat_q[EN +: BITS_PER_T] & mask_q[EN +: BITS_PER_T]);

    // R5
    ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[OVE]) |-> $past(ctrl_q[OVE]));

    if (DLY == 2) begin : g_dchk
      // R8
      irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[n]) |-> $past(pend[n], 2));
      // R8
      irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq[n]) |-> !$past(pend[n], 2));
    end
  end

  always_comb begin
    for (int i = 0; i < EV_W; i++)
      clr[i] = wr_en && (addr == 8'(STAT_BASE + i / 8)) && wdata[i % 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      for (int i = 0; i < CTRL_W; i++)
        if (wr_en && addr == 8'(CTRL_BASE + i / 8)) ctrl_q[i] <= wdata[i % 8];
      for (int i = 0; i < EV_W; i++)
        if (wr_en && addr == 8'(MASK_BASE + i / 8)) mask_q[i] <= wdata[i % 8];
      stat_q <= (stat_q & ~clr) | ev;
    end
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < TMR_N; n++)
      for (int b = 0; b < NB; b++) begin
        if (addr == 8'(n * BANK_STRIDE + b))             rdata = cnt[n][b*8 +: 8];
        if (addr == 8'(n * BANK_STRIDE + MATCH_OFS + b)) rdata = mt[n][b*8 +: 8];
      end
    for (int i = 0; i < CTRL_W; i++)
      if (addr == 8'(CTRL_BASE + i / 8)) rdata[i % 8] = ctrl_q[i];
    for (int i = 0; i < EV_W; i++) begin
      if (addr == 8'(STAT_BASE + i / 8)) rdata[i % 8] = stat_q[i];
      if (addr == 8'(MASK_BASE + i / 8)) rdata[i % 8] = mask_q[i];
    end
  end

  tmr3_delay #(.W(TMR_N), .DEPTH(DLY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pend),
    .dout  (irq)
  );

  for (genvar i = 0; i < EV_W; i++) begin : g_schk
    // R7
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q[i]) |->
        $past(wr_en && (addr == 8'(STAT_BASE + i / 8)) && wdata[i % 8]));
  end
endmodule

// File: tb/tmr3_unit_tb.sv
`timescale 1ns/10ps
module tmr3_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] irq;
  int         nvec = 0;
  int         nerr = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tmr3_unit u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #0.1;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(a + 8'(b), v[b*8 +: 8]);
  endtask

  task automatic rd8(input logic [7:0] a, output logic [7:0] v);
    addr = a; #0.1; v = rdata;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] v);
    for (int b = 0; b < 4; b++) begin
      logic [7:0] t;
      rd8(a + 8'(b), t);
      v[b*8 +: 8] = t;
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #0.1;
  endtask

  task automatic pulse_slow();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    #0.1;
  endtask

  task automatic t_reset();
    logic [7:0] v; logic [31:0] w;
    rd32(8'h00, w); chk("R1 counter0", w, 0);
    rd32(8'h24, w); chk("R1 match2", w, 0);
    rd8(8'h30, v);  chk("R1 ctrl", v, 0);
    rd8(8'h34, v);  chk("R1 status", v, 0);
    rd8(8'h38, v);  chk("R1 mask", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_bytes();
    logic [7:0] v; logic [31:0] w;
    wr32(8'h10, 32'h12345678);
    rd8(8'h10, v);  chk("R2 lsb first", v, 8'h78);
    rd32(8'h10, w); chk("R2 counter1", w, 32'h12345678);
    wr32(8'h14, 32'hCAFEF00D);
    rd32(8'h14, w); chk("R2 match1", w, 32'hCAFEF00D);
  endtask

  task automatic t_up_ovf();
    logic [7:0] v; logic [31:0] w;
    wr(8'h31, 8'h02);
    wr(8'h38, 8'h04);
    wr32(8'h00, 32'hFFFFFFFF);
    wr32(8'h04, 32'h00000055);
    wr(8'h30, 8'h05);
    rd8(8'h34, v); chk("R5 no event before step", v, 0);
    step(1);
    rd8(8'h34, v); chk("R5 up overflow status", v, 8'h04);
    rd32(8'h00, w); chk("R5 up wrap value", w, 0);
    chk("R8 irq not yet +1", irq, 0);
    step(1); chk("R8 irq not yet +2", irq, 0);
    step(1); chk("R8 irq after two cycles", irq, 3'b001);
    wr(8'h30, 8'h00);
    wr(8'h34, 8'h04);
    rd8(8'h34, v); chk("R7 w1c clears", v, 0);
    chk("R8 irq held +0", irq, 3'b001);
    step(1); chk("R8 irq held +1", irq, 3'b001);
    step(1); chk("R8 irq falls +2", irq, 0);
    wr(8'h38, 8'h00);
  endtask

  task automatic t_match();
    logic [7:0] v;
    wr(8'h31, 8'h04);
    wr32(8'h10, 32'h0);
    wr32(8'h14, 32'h5);
    wr(8'h30, 8'h08);
    step(4);
    rd8(8'h34, v); chk("R6 no match at 4", v, 0);
    step(1);
    rd8(8'h34, v); chk("R6 match at 5", v, 8'h08);
    chk("R8 masked off", irq, 0);
    wr(8'h30, 8'h00);
    wr(8'h34, 8'h08);
  endtask

  task automatic t_slow_down();
    logic [7:0] v; logic [31:0] w;
    wr(8'h31, 8'h00);
    wr32(8'h20, 32'h0);
    wr(8'h30, 8'hC0);
    step(3);
    rd32(8'h20, w); chk("R4 slow holds", w, 0);
    pulse_slow();
    rd32(8'h20, w); chk("R5 down wrap", w, 32'hFFFFFFFF);
    rd8(8'h35, v);  chk("R5 overflow disabled", v, 0);
    pulse_slow();
    rd32(8'h20, w); chk("R4 slow step", w, 32'hFFFFFFFE);
    wr(8'h31, 8'h01);
    wr32(8'h20, 32'h0);
    pulse_slow();
    rd8(8'h35, v);  chk("R5 overflow enabled", v, 8'h01);
  endtask

  task automatic t_clear_race();
    logic [7:0] v;
    wr32(8'h20, 32'h0);
    slow_tick = 1'b1;
    wr(8'h35, 8'h01);
    slow_tick = 1'b0;
    rd8(8'h35, v); chk("R7 event beats clear", v, 8'h01);
    wr(8'h35, 8'h01);
    rd8(8'h35, v); chk("R7 clear without event", v, 0);
    wr(8'h30, 8'h00);
    wr(8'h31, 8'h00);
  endtask

  task automatic t_simul();
    logic [7:0] v;
    wr(8'h31, 8'h0F);
    for (int n = 0; n < 3; n++) wr32(8'(n * 16), 32'hFFFFFFFF);
    wr(8'h38, 8'h24);
    wr(8'h39, 8'h01);
    wr(8'h34, 8'hFF);
    wr(8'h35, 8'h01);
    wr(8'h30, 8'hFF);
    pulse_slow();
    rd8(8'h34, v); chk("R9 low status", v, 8'h64);
    rd8(8'h35, v); chk("R9 high status", v, 8'h01);
    chk("R9 irq +0", irq, 0);
    step(1); chk("R9 irq +1", irq, 0);
    step(1); chk("R9 all irq together", irq, 3'b111);
    wr(8'h30, 8'h00);
    wr(8'h31, 8'h00);
    wr(8'h34, 8'hFF);
    wr(8'h35, 8'h01);
    wr(8'h38, 8'h00);
    wr(8'h39, 8'h00);
  endtask

  task automatic t_write_override();
    logic [31:0] w;
    wr(8'h31, 8'h02);
    wr32(8'h00, 32'h0);
    wr(8'h30, 8'h01);
    step(2);
    wr(8'h00, 8'h80);
    rd32(8'h00, w); chk("R10 write overrides step", w, 32'h80);
    step(1);
    rd32(8'h00, w); chk("R10 counting resumes", w, 32'h81);
    wr(8'h30, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(8'h31, 8'hFF);
    rd8(8'h31, v); chk("R3 ctrl upper bits", v, 8'h0F);
    wr(8'h31, 8'h00);
    wr(8'h32, 8'hFF);
    rd8(8'h32, v); chk("R3 ctrl byte2 zero", v, 0);
    wr(8'h3A, 8'hFF);
    rd8(8'h3A, v); chk("R11 unmapped 0x3A", v, 0);
    rd8(8'h08, v); chk("R11 unmapped 0x08", v, 0);
    wr(8'h38, 8'hAB);
    rd8(8'h38, v); chk("R8 mask readback", v, 8'hAB);
    wr(8'h38, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.1;
    t_reset();
    t_bytes();
    t_up_ovf();
    t_match();
    t_slow_down();
    t_clear_race();
    t_simul();
    t_write_override();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nvec++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule